// File: doc/BRIEF.md
# Sixteen-Channel Edge-Programmable PWM Controller

The block drives sixteen PWM pins from one shared 12-bit timebase. A programmable prescaler divides the input clock down to a count tick. A free-running counter advances once per tick through 0..4095 and then wraps. Each channel holds two 12-bit compare points: the counter position where its pin rises and the position where it falls. Because both edges are free, channels can be phase-staggered, and a pulse may span the counter rollover. Two flag bits per channel force the pin permanently high or permanently low.

Software reaches the block through a byte-wide synchronous register port. Each channel owns a block of four byte registers. A broadcast block writes the same register in every channel at once. Two mode registers control sleep, global output inversion and push-pull versus open-drain drive. The block resets asleep. The prescaler is locked unless the block is asleep. After waking, the counter waits a fixed oscillator settle time before it starts.

Top module: `pwm16_ctrl`

## Requirements
- R1: The counter advances once every (prescale+1) clocks and wraps from 4095 to 0, so each channel's waveform repeats every 4096·(prescale+1) clocks.
- R2: Channel n's registers sit at 0x06+4n+k, with k=0 for rise-count low byte, k=1 for rise high, k=2 for fall-count low byte and k=3 for fall high. A high byte holds count bits [11:8] in bits [3:0] and the force flag in bit 4: force-high in the rise high byte, force-low in the fall high byte. Bits [7:5] read 0.
- R3: The force-low flag overrides everything and makes the logical output low. When only force-high is set, the logical output is high. A change to either flag shows on the pins on the clock after its write.
- R4: Otherwise the logical output goes high one clock after the counter equals the rise count, and low one clock after it equals the fall count. Fall wins when the two counts are equal. A fall count below the rise count gives a pulse that wraps through 0.
- R5: While awake, new rise and fall counts take effect only when the counter wraps to 0. While asleep, they are taken over at once.
- R6: A write to 0xFA..0xFD, in the same k order as R2, updates that register in every channel. Reads of these addresses return 0x00.
- R7: The prescale register at 0xFE resets to 30. It accepts writes only while asleep; a value below 3 is stored as 3.
- R8: Bit 4 of the mode register at 0x00 is sleep, and it resets to 1. While asleep, the counter holds at 0 and every pin sits at its inactive level, including channels with force-high set.
- R9: When sleep is cleared, the counter stays at 0 for WAKE_US microseconds of input clocks, computed from CLK_HZ, and then starts counting.
- R10: The mode register at 0x01 holds invert in bit 4 and push-pull in bit 2, and resets to 0x04. Its other bits read 0. When invert is set, every pin shows the inverse of its logical output.
- R11: In push-pull mode every output enable is 1. In open-drain mode a pin's enable is 1 only while that pin is low.
- R12: Addresses not listed above read 0x00, and writes to them change no register.
- R13: Read data is registered. It shows the addressed register one clock after the read strobe and holds between reads. It is 0 after reset.
- R14: After reset, every channel has force-low set and all counts at 0, so all pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one clock per write |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pwm_out | output | 16 | PWM pin levels |
| pwm_oe | output | 16 | Per-pin output enable |

## Verification
Register writes take effect at the strobe edge, and read data is due on the clock after the strobe. The bench therefore samples each read at the falling edge that follows the capturing edge. Force flags, inversion, drive mode and sleep act on the pins combinationally from registers, so they are checked half a clock after the write edge. Compare edges lag the counter by one register. Pulse positions are therefore checked as exact edge counts derived from prescale 3: a 27-clock wake-to-fall interval (10 wake clocks plus 17), a 16384-clock period, a 44-clock wrapped pulse, and 400- and 200-clock pulses that straddle a mid-period count update.

// File: rtl/pwm16_ctrl.sv
module pwm16_ctrl #(
  parameter int N       = 16,
  parameter int CLK_HZ  = 25_000_000,
  parameter int WAKE_US = 500
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   addr,
  input  logic [7:0]   wdata,
  input  logic         wr,
  input  logic         rd,
  output logic [7:0]   rdata,
  output logic [N-1:0] pwm_out,
  output logic [N-1:0] pwm_oe
);
  localparam int CW       = 12;
  localparam int IW       = $clog2(N);
  localparam int WAKE_CYC = (CLK_HZ / 1000) * WAKE_US / 1000;
  localparam int WW       = $clog2(WAKE_CYC + 2);
  localparam int A_MODE1  = 8'h00;
  localparam int A_MODE2  = 8'h01;
  localparam int A_CH0    = 8'h06;
  localparam int A_CHEND  = A_CH0 + 4 * N;
  localparam int A_BC     = 8'hFA;
  localparam int A_PS     = 8'hFE;
  localparam logic [7:0] PS_MIN = 8'd3;
  localparam logic [CW-1:0] CMAX = '1;

  logic          sleep_q, inv_q, pp_q;
  logic [7:0]    presc_q, pre_q;
  logic [CW-1:0] cnt_q;
  logic [WW-1:0] wake_q;

  logic [CW-1:0] on_v  [N];
  logic [CW-1:0] off_v [N];
  logic [CW-1:0] on_s  [N];
  logic [CW-1:0] off_s [N];
  logic          on_f  [N];
  logic          off_f [N];
  logic [N-1:0]  lvl_q, off_fv, lg;

  wire [7:0]    ch_off = addr - 8'(A_CH0);
  wire          ch_hit = (int'(addr) >= A_CH0) && (int'(addr) < A_CHEND);
  wire [IW-1:0] ch_idx = ch_off[IW+1:2];
  wire          bc_hit = (int'(addr) >= A_BC) && (int'(addr) <= A_BC + 3);
  wire [1:0]    fld    = bc_hit ? addr[1:0] + 2'd2 : ch_off[1:0];
  wire          run    = !sleep_q && wake_q == '0;
  wire          tick   = run && pre_q == presc_q;
  wire          wrap   = tick && cnt_q == CMAX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sleep_q <= 1'b1;
      inv_q   <= 1'b0;
      pp_q    <= 1'b1;
      presc_q <= 8'd30;
      wake_q  <= '0;
    end else begin
      if (wr && int'(addr) == A_MODE1) sleep_q <= wdata[4];
      if (wr && int'(addr) == A_MODE2) begin
        inv_q <= wdata[4];
        pp_q  <= wdata[2];
      end
      if (wr && int'(addr) == A_PS && sleep_q)
        presc_q <= (wdata < PS_MIN) ? PS_MIN : wdata;
      if (wr && int'(addr) == A_MODE1 && sleep_q && !wdata[4])
        wake_q <= WW'(WAKE_CYC);
      else if (wake_q != '0)
        wake_q <= wake_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sleep_q) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else if (run) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ch
    wire sel = wr && (bc_hit || (ch_hit && ch_idx == IW'(g)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        on_v[g]  <= '0;
        off_v[g] <= '0;
        on_f[g]  <= 1'b0;
        off_f[g] <= 1'b1;
      end else if (sel) begin
        case (fld)
          2'd0: on_v[g][7:0] <= wdata;
          2'd1: begin on_v[g][CW-1:8] <= wdata[3:0]; on_f[g] <= wdata[4]; end
          2'd2: off_v[g][7:0] <= wdata;
          default: begin off_v[g][CW-1:8] <= wdata[3:0]; off_f[g] <= wdata[4]; end
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        on_s[g]  <= '0;
        off_s[g] <= '0;
        lvl_q[g] <= 1'b0;
      end else if (sleep_q) begin
        on_s[g]  <= on_v[g];
        off_s[g] <= off_v[g];
        lvl_q[g] <= 1'b0;
      end else begin
        if (wrap) begin
          on_s[g]  <= on_v[g];
          off_s[g] <= off_v[g];
        end
        if (cnt_q == off_s[g])     lvl_q[g] <= 1'b0;
        else if (cnt_q == on_s[g]) lvl_q[g] <= 1'b1;
      end
    end

    assign off_fv[g] = off_f[g];
    assign lg[g]     = !sleep_q && !off_f[g] && (on_f[g] || lvl_q[g]);
  end

  assign pwm_out = lg ^ {N{inv_q}};
  assign pwm_oe  = pp_q ? '1 : ~pwm_out;

  logic [7:0] rsel;
  always_comb begin
    rsel = 8'h00;
    if (int'(addr) == A_MODE1)      rsel = {3'b0, sleep_q, 4'b0};
    else if (int'(addr) == A_MODE2) rsel = {3'b0, inv_q, 1'b0, pp_q, 2'b0};
    else if (int'(addr) == A_PS)    rsel = presc_q;
    else if (ch_hit) begin
      case (ch_off[1:0])
        2'd0: rsel = on_v[ch_idx][7:0];
        2'd1: rsel = {3'b0, on_f[ch_idx], on_v[ch_idx][CW-1:8]};
        2'd2: rsel = off_v[ch_idx][7:0];
        default: rsel = {3'b0, off_f[ch_idx], off_v[ch_idx][CW-1:8]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= 8'h00;
    else if (rd) rdata <= rsel;
  end
endmodule

module pwm16_ctrl_chk #(
  parameter int N        = 16,
  parameter int WAKE_CYC = 1,
  parameter int WW       = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd,
  input logic [7:0]   rdata,
  input logic [N-1:0] pwm_out,
  input logic [N-1:0] pwm_oe,
  input logic         sleep_q,
  input logic         inv_q,
  input logic         pp_q,
  input logic [7:0]   presc_q,
  input logic [11:0]  cnt_q,
  input logic [WW-1:0] wake_q,
  input logic [N-1:0] off_fv
);
  // R8
  sleep_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> pwm_out == {N{inv_q}});
  // R8
  sleep_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |=> cnt_q == 12'd0);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cnt_q) && !$past(sleep_q)) |-> cnt_q == 12'($past(cnt_q) + 12'd1));
  // R7
  presc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_q |=> $stable(presc_q));
  // R7
  presc_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q >= 8'd3);
  // R11
  pp_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pp_q |-> &pwm_oe);
  // R3
  fulloff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_q |-> ((pwm_out ^ {N{inv_q}}) & off_fv) == '0);
  // R9
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q != '0) |=> $stable(cnt_q));
  if (WAKE_CYC > 0) begin : g_wk
    // R9
    wake_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_q) |-> wake_q != '0);
  end
  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

bind pwm16_ctrl pwm16_ctrl_chk #(.N(N), .WAKE_CYC(WAKE_CYC), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .rdata(rdata), .pwm_out(pwm_out),
  .pwm_oe(pwm_oe), .sleep_q(sleep_q), .inv_q(inv_q), .pp_q(pp_q),
  .presc_q(presc_q), .cnt_q(cnt_q), .wake_q(wake_q), .off_fv(off_fv)
);

// File: tb/pwm16_ctrl_tb.sv
module pwm16_ctrl_tb;
  localparam int N = 16;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic [N-1:0] pwm_out, pwm_oe;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pwm16_ctrl #(.N(N), .CLK_HZ(20_000), .WAKE_US(500)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe));

  // {write addr, write data, read addr, expected}
  localparam logic [31:0] VEC [11] = '{
    32'h06_12_06_12,  // R2 ch0 rise low
    32'h07_FF_07_1F,  // R2 high byte masks bits 7:5
    32'h45_2A_45_0A,  // R2 ch15 fall high, flag cleared
    32'hFA_55_22_55,  // R6 broadcast reaches ch7
    32'hFA_55_FA_00,  // R6 broadcast reads zero
    32'h46_77_46_00,  // R12 unused reads zero
    32'h46_77_45_0A,  // R12 unused write leaves ch15
    32'hFE_01_FE_03,  // R7 clamp to 3
    32'hFE_09_FE_09,  // R7 accepted while asleep
    32'h01_FF_01_14,  // R10 only bits 4 and 2 kept
    32'h01_04_01_04   // R10 back to push-pull
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [7:0] v);
    addr = a; rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic wait_lvl(input int ch, input logic v);
    while (pwm_out[ch] !== v) @(negedge clk);
  endtask

  task automatic count_high(input int ch, inout int n);
    while (pwm_out[ch] === 1'b1) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-requirements act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, hold;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    chk(rdata == 8'h00, "R13 reset rdata", rdata, 0);
    chk(pwm_out == '0, "R14 reset pins", pwm_out, 0);
    chk(pwm_oe == '1, "R11 reset push-pull enables", pwm_oe, 16'hFFFF);
    rreg(8'h00, v); chk(v == 8'h10, "R8 sleep reset", v, 8'h10);
    rreg(8'h09, v); chk(v == 8'h10, "R14 force-low reset", v, 8'h10);
    rreg(8'h06, v); chk(v == 8'h00, "R14 count reset", v, 0);
    rreg(8'hFE, v); chk(v == 8'h1E, "R7 prescale reset", v, 8'h1E);
    rreg(8'h01, v); chk(v == 8'h04, "R10 mode reset", v, 8'h04);

    for (int i = 0; i < 11; i++) begin
      wreg(VEC[i][31:24], VEC[i][23:16]);
      rreg(VEC[i][15:8], v);
      chk(v == VEC[i][7:0], $sformatf("R2/R6/R7/R10/R12 vector %0d", i), v, VEC[i][7:0]);
    end

    hold = rdata;
    repeat (3) @(negedge clk);
    chk(rdata == hold, "R13 rdata holds", rdata, hold);

    wreg(8'hFA, 8'h00); wreg(8'hFB, 8'h00); wreg(8'hFC, 8'h00); wreg(8'hFD, 8'h10);
    rreg(8'h2D, v); chk(v == 8'h10, "R6 broadcast force-low ch9", v, 8'h10);
    wreg(8'hFE, 8'h03);
    wreg(8'h07, 8'h10); wreg(8'h09, 8'h00);
    chk(pwm_out[0] == 1'b0, "R8 force-high masked asleep", pwm_out[0], 0);
    wreg(8'h0C, 8'h04); wreg(8'h0D, 8'h00);
    wreg(8'h0E, 8'hFA); wreg(8'h0F, 8'h0F); wreg(8'h10, 8'h05); wreg(8'h11, 8'h00);
    wreg(8'h14, 8'h64); wreg(8'h15, 8'h00);

    wreg(8'h00, 8'h00);
    chk(pwm_out[0] == 1'b1, "R3 force-high after wake", pwm_out[0], 1);
    n = 0;
    while (pwm_out[1] !== 1'b1) begin @(negedge clk); n++; end
    while (pwm_out[1] !== 1'b0) begin @(negedge clk); n++; end
    chk(n == W + 17, "R9 wake delay then fall at count 4", n, W + 17);

    n = 0;
    while (pwm_out[1] !== 1'b1) begin @(negedge clk); n++; end
    while (pwm_out[1] !== 1'b0) begin @(negedge clk); n++; end
    chk(n == 16384, "R1 period 4096*(3+1)", n, 16384);

    wreg(8'hFE, 8'h50);
    rreg(8'hFE, v); chk(v == 8'h03, "R7 prescale locked awake", v, 3);

    wait_lvl(2, 1'b0); wait_lvl(2, 1'b1);
    n = 0; count_high(2, n);
    chk(n == 44, "R4 wrapped pulse 4090..5", n, 44);

    wait_lvl(3, 1'b0); wait_lvl(3, 1'b1);
    n = 0;
    wreg(8'h14, 8'h32); n++;
    count_high(3, n);
    chk(n == 400, "R5 mid-period update deferred", n, 400);
    wait_lvl(3, 1'b1);
    n = 0; count_high(3, n);
    chk(n == 200, "R5 update applied after wrap", n, 200);

    wreg(8'h09, 8'h10);
    chk(pwm_out[0] == 1'b0, "R3 force-low overrides force-high", pwm_out[0], 0);

    wreg(8'h01, 8'h10);
    chk(pwm_out[0] == 1'b1, "R10 inverted low channel", pwm_out[0], 1);
    chk(pwm_oe[0] == 1'b0, "R11 open-drain released when high", pwm_oe[0], 0);
    wreg(8'h17, 8'h10); wreg(8'h19, 8'h00);
    chk(pwm_out[4] == 1'b0, "R10 inverted force-high", pwm_out[4], 0);
    chk(pwm_oe[4] == 1'b1, "R11 open-drain drives low", pwm_oe[4], 1);

    wreg(8'h00, 8'h10);
    chk(pwm_out == '1, "R8 asleep inactive inverted", pwm_out, 16'hFFFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule